// File: doc/BRIEF.md
# Data Trace Window and Sync Generator

This block sits beside a CPU bus and decides which completed accesses become data trace messages. Each access carries an address, a data word, a read/write direction and a flag that marks it as instruction-side or data-side. An access is traced when it meets four conditions. It must not be aborted and must not end in a bus error. Its side must equal the globally selected side. Tracing must be enabled for its direction. Its address must satisfy the programmed window, which is either inside or outside two inclusive bounds. A traced access produces a one-cycle message request one clock later. The request carries the address, the data and the direction.

Each message is either plain or synchronizing. Four causes force the next traced access to use the synchronizing form:
- a return from low-power or debug mode;
- an external event strobe, when event triggering is enabled;
- a report from the message queue that an earlier trace message was lost;
- a periodic count, once 255 plain messages have been emitted since the last sync.

The first three causes are kept as sticky pending flags. Causes that are pending together merge into a single sync message. Any sync message clears all pending flags and restarts the periodic count. Message formatting and queuing happen downstream.

Top module: `dtrace_sync_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, msg_valid is 0. The first traced access after reset produces a sync message (msg_sync=1).
- R2: With cfg_outside=0, an access is traced only when cfg_lo <= acc_addr <= cfg_hi. Both bounds are included.
- R3: With cfg_outside=1, an access is traced only when acc_addr < cfg_lo or acc_addr > cfg_hi.
- R4: Reads (acc_write=0) are traced only when cfg_rd_en=1. Writes (acc_write=1) are traced only when cfg_wr_en=1.
- R5: An access is traced only when acc_instr equals cfg_instr_sel. The value 1 selects instruction-side accesses and 0 selects data-side accesses.
- R6: An access with acc_abort=1 or acc_err=1 never produces a message.
- R7: A traced access on cycle N raises msg_valid for exactly cycle N+1. On that cycle msg_addr, msg_data and msg_write carry the values of that access.
- R8: A pulse on lp_exit makes the next traced access a sync message. This holds even when the pulse arrives on the same cycle as that access.
- R9: A pulse on evt_in makes the next traced access a sync message when cfg_evt_en=1. When cfg_evt_en=0, the pulse has no effect.
- R10: A pulse on q_lost makes the next traced access a sync message.
- R11: After a sync message, the following 255 messages are plain and the 256th is a sync message.
- R12: Pending causes survive accesses that are not traced. Several causes merge into one sync message, and the message after it is plain. Every sync message restarts the periodic count of R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A bus access completes this cycle |
| acc_addr | input | AW | Access address |
| acc_data | input | DW | Access data |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_instr | input | 1 | 1 = instruction-side, 0 = data-side access |
| acc_abort | input | 1 | Access was aborted |
| acc_err | input | 1 | Access ended with a data error |
| lp_exit | input | 1 | Pulse: low-power or debug mode left |
| evt_in | input | 1 | Pulse: external event |
| q_lost | input | 1 | Pulse: a trace message was lost in the queue |
| cfg_lo | input | AW | Lower window bound (inclusive) |
| cfg_hi | input | AW | Upper window bound (inclusive) |
| cfg_outside | input | 1 | 1 = trace outside the window, 0 = inside |
| cfg_rd_en | input | 1 | Enable tracing of reads |
| cfg_wr_en | input | 1 | Enable tracing of writes |
| cfg_instr_sel | input | 1 | Side to trace: 1 = instruction, 0 = data |
| cfg_evt_en | input | 1 | Allow evt_in to force a sync message |
| msg_valid | output | 1 | Message request, one cycle per traced access |
| msg_write | output | 1 | Direction of the traced access |
| msg_sync | output | 1 | 1 = sync message, 0 = plain message |
| msg_addr | output | AW | Address of the traced access |
| msg_data | output | DW | Data of the traced access |

## Verification
The checker assumes that the configuration inputs are held steady for at least one cycle around each access. Its window and direction properties compare the message against the configuration sampled on the cycle before. It also assumes that every input is driven to a known level once reset is released. The bench meets both assumptions. It changes configuration only on a falling clock edge between accesses and keeps every access input at a defined value, with the pulse inputs returning to 0 after one cycle.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [1:0] {
    CZ_WAKE = 2'd0,
    CZ_EVT  = 2'd1,
    CZ_LOST = 2'd2
  } cause_e;

  localparam int unsigned NCAUSE = 3;
endpackage

// File: rtl/dts_window.sv
module dts_window #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] addr,
  input  logic          outside,
  output logic          match
);
  logic above_lo;
  logic below_hi;
  logic in_win;

  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    in_win   = above_lo & below_hi;
    match    = in_win ^ outside;
  end
endmodule

// File: rtl/dts_pending.sv
module dts_pending #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic         pend_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_comb begin
      flag_d[g] = (flag_q[g] | set_i[g]) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= flag_d[g];
      end
    end
  end

  always_comb begin
    pend_o = |(flag_q | set_i);
  end
endmodule

// File: rtl/dts_period.sv
module dts_period #(
  parameter int unsigned PERIOD = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic sync_i,
  output logic due_o
);
  localparam int unsigned CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PERIOD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    due_o = (cnt_q == LIMIT);
    if (sync_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LIMIT;
    end else if (adv_i) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dtrace_sync_gen.sv
module dtrace_sync_gen
  import dts_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_PERIOD = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  input  logic          acc_write,
  input  logic          acc_instr,
  input  logic          acc_abort,
  input  logic          acc_err,
  input  logic          lp_exit,
  input  logic          evt_in,
  input  logic          q_lost,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic          cfg_outside,
  input  logic          cfg_rd_en,
  input  logic          cfg_wr_en,
  input  logic          cfg_instr_sel,
  input  logic          cfg_evt_en,
  output logic          msg_valid,
  output logic          msg_write,
  output logic          msg_sync,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);
  logic              win_match;
  logic              clean;
  logic              side_ok;
  logic              dir_ok;
  logic              hit;
  logic              pend_any;
  logic              period_due;
  logic              make_sync;
  logic              emit_sync;
  logic [NCAUSE-1:0] cause_set;
  logic              valid_d;

  dts_window #(.AW(AW)) u_window (
    .lo      (cfg_lo),
    .hi      (cfg_hi),
    .addr    (acc_addr),
    .outside (cfg_outside),
    .match   (win_match)
  );

  always_comb begin
    cause_set          = '0;
    cause_set[CZ_WAKE] = lp_exit;
    cause_set[CZ_EVT]  = evt_in & cfg_evt_en;
    cause_set[CZ_LOST] = q_lost;
  end

  always_comb begin
    clean     = acc_valid & ~acc_abort & ~acc_err;
    side_ok   = (acc_instr == cfg_instr_sel);
    dir_ok    = acc_write ? cfg_wr_en : cfg_rd_en;
    hit       = clean & side_ok & dir_ok & win_match;
    make_sync = pend_any | period_due;
    emit_sync = hit & make_sync;
    valid_d   = hit;
  end

  dts_pending #(.N(NCAUSE)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (cause_set),
    .clr_i  (emit_sync),
    .pend_o (pend_any)
  );

  dts_period #(.PERIOD(SYNC_PERIOD)) u_period (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (hit),
    .sync_i (make_sync),
    .due_o  (period_due)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
    end else begin
      msg_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_write <= 1'b0;
      msg_sync  <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (hit) begin
      msg_write <= acc_write;
      msg_sync  <= make_sync;
      msg_addr  <= acc_addr;
      msg_data  <= acc_data;
    end
  end
endmodule

// File: rtl/dts_sync_gen_chk.sv
module dts_sync_gen_chk #(
  parameter int unsigned AW          = 32,
  parameter int unsigned SYNC_PERIOD = 255
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_instr,
  input logic          acc_abort,
  input logic          acc_err,
  input logic          lp_exit,
  input logic [AW-1:0] cfg_lo,
  input logic [AW-1:0] cfg_hi,
  input logic          cfg_outside,
  input logic          cfg_rd_en,
  input logic          cfg_wr_en,
  input logic          cfg_instr_sel,
  input logic          msg_valid,
  input logic          msg_write,
  input logic          msg_sync,
  input logic [AW-1:0] msg_addr
);
  localparam int unsigned CW = $clog2(SYNC_PERIOD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SYNC_PERIOD);

  logic [CW-1:0] plain_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_run <= LIMIT;
    end else if (msg_valid) begin
      plain_run <= msg_sync ? '0 : plain_run + 1'b1;
    end
  end

  // R7: no message without an access one cycle earlier
  a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(acc_valid));

  // R6: aborted or errored accesses never produce a message
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_abort || acc_err)) |=> !msg_valid);

  // R4: direction enables
  a_r4_wr_en: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_write) |-> $past(cfg_wr_en));
  a_r4_rd_en: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_write) |-> $past(cfg_rd_en));

  // R2: inside mode keeps the address within inclusive bounds
  a_r2_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !$past(cfg_outside)) |->
      ((msg_addr >= $past(cfg_lo)) && (msg_addr <= $past(cfg_hi))));

  // R3: outside mode keeps the address off the window
  a_r3_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && $past(cfg_outside)) |->
      ((msg_addr < $past(cfg_lo)) || (msg_addr > $past(cfg_hi))));

  // R5: wrong side never traced
  a_r5_side: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_instr != cfg_instr_sel)) |=> !msg_valid);

  // R8: wake exit on the access cycle forces sync
  a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && lp_exit) |=> (!msg_valid || msg_sync));

  // R11: no more than SYNC_PERIOD plain messages in a row
  a_r11_period: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_sync) |-> (plain_run < LIMIT));
endmodule

bind dtrace_sync_gen dts_sync_gen_chk #(
  .AW          (AW),
  .SYNC_PERIOD (SYNC_PERIOD)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid     (acc_valid),
  .acc_instr     (acc_instr),
  .acc_abort     (acc_abort),
  .acc_err       (acc_err),
  .lp_exit       (lp_exit),
  .cfg_lo        (cfg_lo),
  .cfg_hi        (cfg_hi),
  .cfg_outside   (cfg_outside),
  .cfg_rd_en     (cfg_rd_en),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_instr_sel (cfg_instr_sel),
  .msg_valid     (msg_valid),
  .msg_write     (msg_write),
  .msg_sync      (msg_sync),
  .msg_addr      (msg_addr)
);

// File: tb/test_dtrace_sync_gen.sv
module test_dtrace_sync_gen;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;

  logic          clk;
  logic          rst_n;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_data;
  logic          acc_write;
  logic          acc_instr;
  logic          acc_abort;
  logic          acc_err;
  logic          lp_exit;
  logic          evt_in;
  logic          q_lost;
  logic [AW-1:0] cfg_lo;
  logic [AW-1:0] cfg_hi;
  logic          cfg_outside;
  logic          cfg_rd_en;
  logic          cfg_wr_en;
  logic          cfg_instr_sel;
  logic          cfg_evt_en;
  logic          msg_valid;
  logic          msg_write;
  logic          msg_sync;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;

  int total;
  int fails;

  dtrace_sync_gen #(.AW(AW), .DW(DW), .SYNC_PERIOD(255)) i_dtrace_sync_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_addr      (acc_addr),
    .acc_data      (acc_data),
    .acc_write     (acc_write),
    .acc_instr     (acc_instr),
    .acc_abort     (acc_abort),
    .acc_err       (acc_err),
    .lp_exit       (lp_exit),
    .evt_in        (evt_in),
    .q_lost        (q_lost),
    .cfg_lo        (cfg_lo),
    .cfg_hi        (cfg_hi),
    .cfg_outside   (cfg_outside),
    .cfg_rd_en     (cfg_rd_en),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_instr_sel (cfg_instr_sel),
    .cfg_evt_en    (cfg_evt_en),
    .msg_valid     (msg_valid),
    .msg_write     (msg_write),
    .msg_sync      (msg_sync),
    .msg_addr      (msg_addr),
    .msg_data      (msg_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        ins;
    logic        ab;
    logic        er;
    logic        ev;
    logic        es;
  } vec_t;

  // window 0x100..0x1FF inside, both directions, data side
  localparam vec_t VEC [0:7] = '{
    '{32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R1 first is sync, R2 low bound
    '{32'h0000_01FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 high bound
    '{32'h0000_0200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 above
    '{32'h0000_00FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 below
    '{32'h0000_0150, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 abort
    '{32'h0000_0150, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 error
    '{32'h0000_0150, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 wrong side
    '{32'h0000_0180, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}  // R7 plain
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    acc_valid = 1'b0;
    acc_abort = 1'b0;
    acc_err   = 1'b0;
    lp_exit   = 1'b0;
    evt_in    = 1'b0;
    q_lost    = 1'b0;
  endtask

  // drive at a falling edge, check the registered result one cycle later
  task automatic do_acc(input string req, input logic [31:0] a, input logic wr,
                        input logic ins, input logic ab, input logic er,
                        input logic ev, input logic es);
    logic [31:0] d;
    d         = a ^ 32'hA5A5_0000;
    acc_valid = 1'b1;
    acc_addr  = a;
    acc_data  = d;
    acc_write = wr;
    acc_instr = ins;
    acc_abort = ab;
    acc_err   = er;
    @(negedge clk);
    clear_pulses();
    chk(req, {31'd0, msg_valid}, {31'd0, ev});
    if (ev && msg_valid) begin
      chk(req, {31'd0, msg_sync}, {31'd0, es});
      chk({req, " R7 addr"}, msg_addr, a);
      chk({req, " R7 data"}, msg_data, d);
      chk({req, " R7 dir"}, {31'd0, msg_write}, {31'd0, wr});
    end
  endtask

  task automatic pulse(input logic lp, input logic ev, input logic ls);
    lp_exit = lp;
    evt_in  = ev;
    q_lost  = ls;
    @(negedge clk);
    clear_pulses();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    total = 0;
    fails = 0;
    rst_n = 1'b0;
    clear_pulses();
    acc_addr      = '0;
    acc_data      = '0;
    acc_write     = 1'b0;
    acc_instr     = 1'b0;
    cfg_lo        = 32'h0000_0100;
    cfg_hi        = 32'h0000_01FF;
    cfg_outside   = 1'b0;
    cfg_rd_en     = 1'b1;
    cfg_wr_en     = 1'b1;
    cfg_instr_sel = 1'b0;
    cfg_evt_en    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, msg_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset valid", {31'd0, msg_valid}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      do_acc($sformatf("vec%0d", i), VEC[i].addr, VEC[i].wr, VEC[i].ins,
             VEC[i].ab, VEC[i].er, VEC[i].ev, VEC[i].es);
    end

    // R7 single-cycle valid
    @(negedge clk);
    chk("R7 one cycle", {31'd0, msg_valid}, 32'd0);

    // R3 outside mode
    cfg_outside = 1'b1;
    do_acc("R3 below", 32'h0000_0050, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    do_acc("R3 inside dropped", 32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_acc("R3 above", 32'h0000_0200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg_outside = 1'b0;

    // R4 direction enables
    cfg_rd_en = 1'b0;
    do_acc("R4 read off", 32'h0000_0120, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_acc("R4 write on", 32'h0000_0120, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg_rd_en = 1'b1;
    cfg_wr_en = 1'b0;
    do_acc("R4 write off", 32'h0000_0124, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_acc("R4 read on", 32'h0000_0124, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg_wr_en = 1'b1;

    // R5 instruction side selected
    cfg_instr_sel = 1'b1;
    do_acc("R5 data dropped", 32'h0000_0130, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_acc("R5 instr traced", 32'h0000_0130, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg_instr_sel = 1'b0;

    // R8 wake exit, separate cycle, held across a filtered access (R12)
    pulse(1'b1, 1'b0, 1'b0);
    do_acc("R12 sticky filtered", 32'h0000_0300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_acc("R8 wake sync", 32'h0000_0140, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    do_acc("R8 cleared", 32'h0000_0144, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R8 same cycle
    lp_exit = 1'b1;
    do_acc("R8 same cycle", 32'h0000_0148, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R9 event gated by enable
    pulse(1'b0, 1'b1, 1'b0);
    do_acc("R9 event disabled", 32'h0000_0150, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg_evt_en = 1'b1;
    pulse(1'b0, 1'b1, 1'b0);
    do_acc("R9 event enabled", 32'h0000_0154, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R10 lost message
    pulse(1'b0, 1'b0, 1'b1);
    do_acc("R10 lost sync", 32'h0000_0158, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R12 merge: all causes give one sync, then plain
    pulse(1'b1, 1'b1, 1'b1);
    do_acc("R12 merged sync", 32'h0000_015C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    do_acc("R12 merged then plain", 32'h0000_0160, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R11 and R12: periodic count restarts at the last sync
    for (int i = 0; i < 20; i++) begin
      do_acc("R11 filler", 32'h0000_0100 + i, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    end
    pulse(1'b0, 1'b0, 1'b1);
    do_acc("R12 restart sync", 32'h0000_0170, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 255; i++) begin
      do_acc("R11 plain run", 32'h0000_0100 + i, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    end
    do_acc("R11 periodic sync", 32'h0000_01F0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    do_acc("R11 after periodic", 32'h0000_01F4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule